// File: doc/BRIEF.md
# Interrupt Controller Slice

This block gathers a word of interrupt request pins and turns them into two request lines for a processor or a parent controller: one for ordinary service and one for critical service. Each pin can be set to react to a level or to a transition, and to treat high or low as its active sense. Once an activation is seen, it is held in a pending register until software acknowledges it. The enable register decides which pending bits may reach an output. The critical-select register decides which of the two outputs each enabled bit drives.

Software reaches the registers through a small word-wide bus. It has a 3-bit address, a write strobe and write data, and the read data is returned in the same cycle. Pin n always appears at register bit NUM_IN-1-n, so pin 0 is the top bit of every register. Pending bits are acknowledged by writing ones. A read-only word shows only the pending bits that are also enabled.

Top module: `intc_slice`

## Requirements
- R1: Pin n of `irq_pin_i` maps to bit NUM_IN-1-n of every register. With NUM_IN=32, pin 0 is bit 31 and pin 31 is bit 0.
- R2: The register addresses are: 0 pending (write-one-to-clear), 1 enable, 2 critical-select, 3 polarity, 4 trigger mode, 5 masked pending (read-only). A write to addresses 1 to 4 is visible on read from the next cycle. A write to address 5 changes nothing. Addresses 6 and 7 read as zero.
- R3: Writing 1 to a pending bit clears it. Writing 0 leaves it as it was. Writing all ones clears every bit that has no edge event in that same cycle.
- R4: A trigger bit of 0 makes the pin level-sensitive. Its pending bit sets two clocks after the pin becomes active. In the cycle of a clear it reads 0, and it sets again one cycle later if the pin is still active.
- R5: A trigger bit of 1 makes the pin edge-sensitive. Its pending bit sets once for each transition in the selected direction. A pin held steady does not set it again after a clear. An edge event that falls in the same cycle as a clear write of that bit keeps the bit set.
- R6: A polarity bit of 1 selects active-high (a rising edge). A polarity bit of 0 selects active-low (a falling edge).
- R7: The masked pending word reads as pending AND enable.
- R8: `irq_norm_o` is the OR of the masked pending bits whose critical-select bit is 0. `irq_crit_o` is the OR of the masked pending bits whose critical-select bit is 1.
- R9: After reset the enable, critical-select, polarity and trigger registers read 0, and both outputs are low.
- R10: Pending bits latch whatever the enable bit is. A disabled pin can become pending without driving any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_pin_i | input | NUM_IN | Interrupt request pins, pin n at index n |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_IN | Write data |
| reg_rdata_o | output | NUM_IN | Read data for reg_addr_i, same cycle |
| irq_norm_o | output | 1 | Ordinary interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
A software acknowledge and a new activation can land on the same pending bit in the same clock. The result then depends on the trigger mode. For an edge-sensitive pin, the bench drives the transition one clock before the clear write, so that the detected event and the write strike the same edge, and expects the bit to remain pending. For a level-sensitive pin held active, the bench reads the bit between the clear edge and the following one, expecting 0 and then 1.

// File: rtl/intc_pkg.sv
package intc_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      ADR_PEND  = 3'd0,
      ADR_EN    = 3'd1,
      ADR_CRIT  = 3'd2,
      ADR_POL   = 3'd3,
      ADR_TRIG  = 3'd4,
      ADR_MPEND = 3'd5
   } reg_addr_e;
endpackage

// File: rtl/intc_cond.sv
// Pin conditioning: bit reversal into register order, two-stage registering,
// polarity and trigger selection.
module intc_cond #(
   parameter int N = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] pin_i,
   input  logic [N-1:0] pol_i,
   input  logic [N-1:0] trig_i,
   output logic [N-1:0] lvl_act_o,
   output logic [N-1:0] edge_evt_o
);
   logic [N-1:0] pin_r;
   logic [N-1:0] now_q;
   logic [N-1:0] old_q;

   for (genvar g = 0; g < N; g++) begin : g_rev
      assign pin_r[N-1-g] = pin_i[g];
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         now_q <= '0;
         old_q <= '0;
      end else begin
         now_q <= pin_r;
         old_q <= now_q;
      end
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic cur_act;
      logic prev_act;
      assign cur_act       = pol_i[b] ? now_q[b] : ~now_q[b];
      assign prev_act      = pol_i[b] ? old_q[b] : ~old_q[b];
      assign lvl_act_o[b]  = ~trig_i[b] & cur_act;
      assign edge_evt_o[b] =  trig_i[b] & cur_act & ~prev_act;
   end
endmodule

// File: rtl/intc_status.sv
// Pending register: level sets are masked by a clear in the same cycle,
// edge events win over a clear.
module intc_status #(
   parameter int N = 32
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] lvl_act_i,
   input  logic [N-1:0] edge_evt_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);
   logic [N-1:0] pend_q;
   logic [N-1:0] pend_d;

   always_comb begin
      pend_d = ((pend_q | lvl_act_i) & ~clr_i) | edge_evt_i;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= pend_d;
   end

   assign pend_o = pend_q;

   // R3
   clr_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_q & $past(clr_i & ~edge_evt_i)) == '0));

   // R5
   edge_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_q & $past(edge_evt_i)) == $past(edge_evt_i)));

   // R4
   set_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((pend_q & ~$past(pend_q) & ~$past(lvl_act_i | edge_evt_i)) == '0));
endmodule

// File: rtl/intc_route.sv
// Masking and routing to the two request outputs.
module intc_route #(
   parameter int N = 32
) (
   input  logic [N-1:0] pend_i,
   input  logic [N-1:0] en_i,
   input  logic [N-1:0] crit_i,
   output logic [N-1:0] masked_o,
   output logic         irq_norm_o,
   output logic         irq_crit_o
);
   assign masked_o   = pend_i & en_i;
   assign irq_norm_o = |(masked_o & ~crit_i);
   assign irq_crit_o = |(masked_o &  crit_i);
endmodule

// File: rtl/intc_slice.sv
module intc_slice #(
   parameter int NUM_IN = 32
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_IN-1:0]         irq_pin_i,
   input  logic [intc_pkg::ADDR_W-1:0] reg_addr_i,
   input  logic                      reg_we_i,
   input  logic [NUM_IN-1:0]         reg_wdata_i,
   output logic [NUM_IN-1:0]         reg_rdata_o,
   output logic                      irq_norm_o,
   output logic                      irq_crit_o
);
   import intc_pkg::*;

   localparam int DW = NUM_IN;

   if (NUM_IN < 1 || NUM_IN > 64) begin : g_bad_width
      $error("intc_slice: NUM_IN must be within 1..64");
   end

   logic [DW-1:0] en_q, crit_q, pol_q, trig_q;
   logic [DW-1:0] lvl_act, edge_evt, pend, masked, clr;
   logic          wr_pend, wr_en, wr_crit, wr_pol, wr_trig;

   assign wr_pend = reg_we_i && (reg_addr_i == ADR_PEND);
   assign wr_en   = reg_we_i && (reg_addr_i == ADR_EN);
   assign wr_crit = reg_we_i && (reg_addr_i == ADR_CRIT);
   assign wr_pol  = reg_we_i && (reg_addr_i == ADR_POL);
   assign wr_trig = reg_we_i && (reg_addr_i == ADR_TRIG);
   assign clr     = wr_pend ? reg_wdata_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q   <= '0;
         crit_q <= '0;
         pol_q  <= '0;
         trig_q <= '0;
      end else begin
         if (wr_en)   en_q   <= reg_wdata_i;
         if (wr_crit) crit_q <= reg_wdata_i;
         if (wr_pol)  pol_q  <= reg_wdata_i;
         if (wr_trig) trig_q <= reg_wdata_i;
      end
   end

   intc_cond #(.N(DW)) u_cond (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (irq_pin_i),
      .pol_i      (pol_q),
      .trig_i     (trig_q),
      .lvl_act_o  (lvl_act),
      .edge_evt_o (edge_evt)
   );

   intc_status #(.N(DW)) u_status (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .lvl_act_i  (lvl_act),
      .edge_evt_i (edge_evt),
      .clr_i      (clr),
      .pend_o     (pend)
   );

   intc_route #(.N(DW)) u_route (
      .pend_i     (pend),
      .en_i       (en_q),
      .crit_i     (crit_q),
      .masked_o   (masked),
      .irq_norm_o (irq_norm_o),
      .irq_crit_o (irq_crit_o)
   );

   always_comb begin
      case (reg_addr_i)
         ADR_PEND:  reg_rdata_o = pend;
         ADR_EN:    reg_rdata_o = en_q;
         ADR_CRIT:  reg_rdata_o = crit_q;
         ADR_POL:   reg_rdata_o = pol_q;
         ADR_TRIG:  reg_rdata_o = trig_q;
         ADR_MPEND: reg_rdata_o = masked;
         default:   reg_rdata_o = '0;
      endcase
   end

   // R2
   en_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en |=> (en_q == $past(reg_wdata_i)));

   // R2
   trig_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !wr_trig |=> $stable(trig_q));
endmodule

// File: tb/intc_slice_tb_top.sv
module intc_slice_tb_top;
   localparam int N = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  pins = '0;
   logic [2:0]    addr = 3'd0;
   logic          we = 1'b0;
   logic [N-1:0]  wdata = '0;
   logic [N-1:0]  rdata;
   logic          irq_norm, irq_crit;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   intc_slice #(.NUM_IN(N)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pins),
      .reg_addr_i(addr), .reg_we_i(we), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_norm_o(irq_norm), .irq_crit_o(irq_crit)
   );

   typedef struct packed {
      logic [31:0] pol, trig, en, crit, a, b, pend;
      logic        norm, critl;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VEC [NV] = '{
      '{32'hFFFFFFFF, 32'h0,        32'hFFFFFFFF, 32'h0,        32'h0,        32'h000000F0, 32'h000000F0, 1'b1, 1'b0},
      '{32'h0,        32'h0,        32'h0000FFFF, 32'h0000FF00, 32'hFFFFFFFF, 32'hFFFF00FF, 32'h0000FF00, 1'b0, 1'b1},
      '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,        32'h0000000F, 32'h000000FF, 32'h000000F0, 1'b1, 1'b0},
      '{32'h0,        32'hFFFFFFFF, 32'hF0000000, 32'hF0000000, 32'hFFFFFFFF, 32'h0FFFFFFF, 32'hF0000000, 1'b0, 1'b1},
      '{32'hFFFF0000, 32'h00FF00FF, 32'hFFFFFFFF, 32'h0,        32'h0000FF00, 32'hAAAA5555, 32'hAAAAAA00, 1'b1, 1'b0},
      '{32'hFFFFFFFF, 32'h0,        32'h0,        32'h0,        32'h0,        32'h00000001, 32'h00000001, 1'b0, 1'b0}
   };

   // register-order word to pin vector (R1: pin n is bit 31-n)
   function automatic logic [N-1:0] to_pins(input logic [N-1:0] v);
      for (int i = 0; i < N; i++) to_pins[i] = v[N-1-i];
   endfunction

   task automatic chk(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(posedge clk);
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
      addr = a;
      #0.5;
      d = rdata;
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_pins(input logic [N-1:0] regword);
      @(negedge clk);
      pins = to_pins(regword);
   endtask

   logic [N-1:0] v;

   initial begin
      wait_clk(3);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      rd(3'd1, v); chk("R9 enable", v, '0);
      rd(3'd2, v); chk("R9 critsel", v, '0);
      rd(3'd3, v); chk("R9 polarity", v, '0);
      rd(3'd4, v); chk("R9 trigger", v, '0);
      chk("R9 outputs", {30'd0, irq_norm, irq_crit}, '0);
      rd(3'd7, v); chk("R2 unused address", v, '0);

      // table walk: R4 R5 R6 R7 R8 R10
      for (int k = 0; k < NV; k++) begin
         wr(3'd3, VEC[k].pol);
         wr(3'd4, VEC[k].trig);
         wr(3'd1, VEC[k].en);
         wr(3'd2, VEC[k].crit);
         set_pins(VEC[k].a);
         wait_clk(4);
         wr(3'd0, 32'hFFFFFFFF);
         pins = to_pins(VEC[k].b);
         wait_clk(4);
         rd(3'd0, v); chk($sformatf("R4/R5/R6/R10 pending vec%0d", k), v, VEC[k].pend);
         rd(3'd5, v); chk($sformatf("R7 masked vec%0d", k), v, VEC[k].pend & VEC[k].en);
         chk($sformatf("R8 outputs vec%0d", k), {30'd0, irq_norm, irq_crit},
             {30'd0, VEC[k].norm, VEC[k].critl});
      end
      rd(3'd3, v); chk("R2 polarity readback", v, 32'hFFFFFFFF);

      // R1 bit mapping: pin 0 -> bit 31
      wr(3'd4, 32'h0); wr(3'd1, 32'h0);
      set_pins(32'h0); wait_clk(4);
      wr(3'd0, 32'hFFFFFFFF);
      pins = 32'h00000001;
      wait_clk(4);
      rd(3'd0, v); chk("R1 pin0 to bit31", v, 32'h80000000);

      // R3 partial clear on edge pins
      wr(3'd4, 32'hFFFFFFFF);
      set_pins(32'h0); wait_clk(4);
      wr(3'd0, 32'hFFFFFFFF);
      set_pins(32'h000000F0); wait_clk(4);
      rd(3'd0, v); chk("R3 pending before clear", v, 32'h000000F0);
      wr(3'd0, 32'h00000010);
      rd(3'd0, v); chk("R3 clear one bit", v, 32'h000000E0);
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R3 write zero no effect", v, 32'h000000E0);

      // R2 write to masked address is ignored
      wr(3'd5, 32'hFFFFFFFF);
      rd(3'd0, v); chk("R2 masked write pending", v, 32'h000000E0);
      rd(3'd1, v); chk("R2 masked write enable", v, 32'h0);

      // R5 edge held steady: no re-latch after clear
      wr(3'd0, 32'hFFFFFFFF); wait_clk(3);
      rd(3'd0, v); chk("R5 held edge no relatch", v, 32'h0);

      // R5 edge event coinciding with clear write
      set_pins(32'h80000000);
      wr(3'd0, 32'h80000000);
      rd(3'd0, v); chk("R5 edge beats clear", v, 32'h80000000);
      wr(3'd0, 32'h80000000);
      rd(3'd0, v); chk("R5 later clear", v, 32'h0);

      // R4 level re-latch timing
      wr(3'd4, 32'h0);
      set_pins(32'h00000001); wait_clk(4);
      rd(3'd0, v); chk("R4 level set", v & 32'h1, 32'h1);
      wr(3'd0, 32'h00000001);
      rd(3'd0, v); chk("R4 cleared in clear cycle", v & 32'h1, 32'h0);
      @(negedge clk);
      rd(3'd0, v); chk("R4 relatch next cycle", v & 32'h1, 32'h1);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #400000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule